// File: doc/BRIEF.md
# Prioritized DMA Completion Interrupt Vector Unit

This block gathers the end-of-transfer events of a set of DMA channels into per-channel pending flags and turns them into a single interrupt request for a CPU. Each channel's flag is set by a one-cycle terminal-count pulse from that channel's size counter. It is then masked by a per-channel enable bit and by a global enable. A fixed priority, with channel 0 first, selects which pending enabled channel the vector register reports.

Software reaches four registers through a simple strobe bus: the pending flags, the per-channel enables, the vector and a control word. Any read or write of the vector clears the one flag that the vector names. An interrupt routine that reads the vector once per entry therefore services the channels one by one, highest priority first. It never has to write the flag register.

The request output comes from a three-state machine. ST_QUIET means no enabled flag is pending. ST_MASKED means an enabled flag is pending but the global enable is off. ST_REQUEST means an enabled flag is pending and the global enable is on. Each clock, the machine moves to whichever of these three states matches the values that the flags and enables take at that edge. The transitions are named go_quiet, go_masked and go_request. Only ST_REQUEST drives the request output.

Top module: `dma_irq_vector`

## Requirements
- R1: A one-cycle pulse on `tc_pulse[n]` sets the flag of channel n, and the flag can be seen at the next clock edge.
- R2: `irq` is high only when some channel has its flag and its enable set while the global enable (bit 0 of the control register, address 3) is also set.
- R3: Flags are never cleared on their own. Writing the flag register (address 0) clears each flag whose bit in `bus_wdata` is 1 and leaves the other flags unchanged.
- R4: When several enabled flags are pending, the vector reports the lowest-numbered channel.
- R5: The vector code (address 2) is 0 when no enabled flag is pending and 2×(n+1) for channel n. A read returns the code in `bus_rdata` on the clock edge that follows the cycle in which `bus_rd` is high.
- R6: A flag whose enable bit is 0 has no effect on the vector code.
- R7: A read or a write of the vector register clears only the flag that the vector named at that moment.
- R8: When enabled flags remain pending after a vector access and the global enable is on, `irq` stays high.
- R9: When a terminal-count pulse arrives in the same cycle as a vector access that clears that channel's flag, the flag stays set.
- R10: The enable register (address 1, bit n for channel n) and the control register read back the values that were written to them.
- R11: After reset, all flags, enables, the global enable and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tc_pulse | input | NUM_CH | Per-channel terminal-count pulse |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- `irq` agrees with the flags, the enables and the global enable.
- The vector code is even, within range, and always names a channel that is both set and enabled.
- A terminal-count pulse always leaves its flag set.
- A flag never drops when there is neither a write nor a vector read.
- An uncontested vector access lowers the number of set flags by exactly one.

Only the bench scenarios can show the following:
- The priority order among several pending channels.
- The exact codes returned on the bus.
- That a masked channel is skipped, so that a lower-priority channel is cleared instead.
- The selective effect of a flag-register write.

// File: rtl/divu_pkg.sv
package divu_pkg;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_MASKED  = 2'd1,
        ST_REQUEST = 2'd2
    } req_state_e;

    localparam logic [1:0] REG_FLAGS  = 2'd0;
    localparam logic [1:0] REG_ENABLE = 2'd1;
    localparam logic [1:0] REG_VECTOR = 2'd2;
    localparam logic [1:0] REG_CTRL   = 2'd3;

endpackage

// File: rtl/divu_prio_enc.sv
module divu_prio_enc #(
    parameter int NUM_CH = 3,
    parameter int CODE_W = 3
) (
    input  logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] winner,
    output logic [CODE_W-1:0] code
);
    // blocked[i] is set when any channel above i in priority is pending
    logic [NUM_CH:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chain
            assign blocked[g+1] = blocked[g] | pend[g];
            assign winner[g]    = pend[g] & ~blocked[g];
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (winner[i]) begin
                code = code | CODE_W'(2 * (i + 1));
            end
        end
    end

endmodule

// File: rtl/divu_flag_bank.sv
module divu_flag_bank #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_req,
    input  logic [NUM_CH-1:0] clr_req,
    output logic [NUM_CH-1:0] flags_q,
    output logic [NUM_CH-1:0] flags_d
);
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_flag
            // a set in the same cycle as a clear wins, so the event is kept
            assign flags_d[g] = set_req[g] | (flags_q[g] & ~clr_req[g]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags_q[g] <= 1'b0;
                end else begin
                    flags_q[g] <= flags_d[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/divu_req_fsm.sv
module divu_req_fsm
    import divu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend_nxt,
    input  logic       gie_nxt,
    output req_state_e state,
    output logic       irq
);
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_QUIET;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_QUIET, ST_MASKED, ST_REQUEST: begin
                if (!pend_nxt) begin
                    state_d = ST_QUIET;         // go_quiet
                end else if (!gie_nxt) begin
                    state_d = ST_MASKED;        // go_masked
                end else begin
                    state_d = ST_REQUEST;       // go_request
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq = (state == ST_REQUEST);
    end

endmodule

// File: rtl/dma_irq_vector.sv
module dma_irq_vector
    import divu_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_pulse,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CODE_W = $clog2(2 * NUM_CH + 1);

    logic [NUM_CH-1:0] flags_q, flags_d;
    logic [NUM_CH-1:0] en_q, en_d;
    logic              gie_q, gie_d;
    logic [NUM_CH-1:0] winner;
    logic [CODE_W-1:0] vec_code;
    logic [NUM_CH-1:0] clr_req;
    logic              wr_flags, wr_enable, wr_ctrl, vec_access;
    req_state_e        req_state;

    assign wr_flags   = bus_wr && (bus_addr == REG_FLAGS);
    assign wr_enable  = bus_wr && (bus_addr == REG_ENABLE);
    assign wr_ctrl    = bus_wr && (bus_addr == REG_CTRL);
    assign vec_access = (bus_wr || bus_rd) && (bus_addr == REG_VECTOR);

    divu_prio_enc #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_prio (
        .pend   (flags_q & en_q),
        .winner (winner),
        .code   (vec_code)
    );

    always_comb begin
        clr_req = '0;
        if (wr_flags)   clr_req = clr_req | bus_wdata[NUM_CH-1:0];
        if (vec_access) clr_req = clr_req | winner;
    end

    divu_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (tc_pulse),
        .clr_req (clr_req),
        .flags_q (flags_q),
        .flags_d (flags_d)
    );

    assign en_d  = wr_enable ? bus_wdata[NUM_CH-1:0] : en_q;
    assign gie_d = wr_ctrl ? bus_wdata[0] : gie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            gie_q <= gie_d;
        end
    end

    divu_req_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (|(flags_d & en_d)),
        .gie_nxt  (gie_d),
        .state    (req_state),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                REG_FLAGS:  bus_rdata <= DATA_W'(flags_q);
                REG_ENABLE: bus_rdata <= DATA_W'(en_q);
                REG_VECTOR: bus_rdata <= DATA_W'(vec_code);
                REG_CTRL:   bus_rdata <= DATA_W'(gie_q);
                default:    bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/divu_checker.sv
module divu_checker #(
    parameter int NUM_CH = 3,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tc_pulse,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [NUM_CH-1:0] flags,
    input logic [NUM_CH-1:0] enables,
    input logic              gie,
    input logic [CODE_W-1:0] vec_code,
    input logic              irq
);
    logic vec_ok;

    always_comb begin
        vec_ok = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(vec_code) == 2 * (i + 1)) vec_ok = flags[i] && enables[i];
        end
    end

    p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && |(flags & enables)));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && |(flags & enables)) |-> irq);

    p_tc_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_pulse) |=> ((flags & $past(tc_pulse)) == $past(tc_pulse)));

    p_no_autoclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !(bus_rd && bus_addr == 2'd2)) |=>
        ((flags & $past(flags)) == $past(flags)));

    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code[0] == 1'b0) && (int'(vec_code) <= 2 * NUM_CH));

    p_vec_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> vec_ok);

    p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_addr == 2'd2 && vec_code != '0 && tc_pulse == '0)
        |=> ($countones(flags) + 1 == $countones($past(flags))));

endmodule

bind dma_irq_vector divu_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tc_pulse (tc_pulse),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .flags    (flags_q),
    .enables  (en_q),
    .gie      (gie_q),
    .vec_code (vec_code),
    .irq      (irq)
);

// File: tb/dma_irq_vector_tb.sv
module dma_irq_vector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 3;
    localparam int DATA_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] tc_pulse = '0;
    logic [1:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    dma_irq_vector #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dut (
        .clk, .rst_n, .tc_pulse, .bus_addr, .bus_wr, .bus_rd,
        .bus_wdata, .bus_rdata, .irq
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [DATA_W-1:0] data;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    logic [NUM_CH-1:0] m_flags = '0;
    logic [NUM_CH-1:0] m_en = '0;
    logic              m_gie = 1'b0;

    function automatic logic [NUM_CH-1:0] m_winner();
        for (int i = 0; i < NUM_CH; i++)
            if (m_flags[i] && m_en[i]) return NUM_CH'(1) << i;
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return DATA_W'(m_flags);
            2'd1: return DATA_W'(m_en);
            2'd3: return DATA_W'(m_gie);
            default: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (m_flags[i] && m_en[i]) return DATA_W'(2 * (i + 1));
                return '0;
            end
        endcase
    endfunction

    // monitor: compare read data one edge after each read strobe
    logic mon_rd = 1'b0;
    always @(posedge clk) mon_rd <= bus_rd;

    always @(negedge clk) begin
        exp_t e;
        if (mon_rd && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (bus_rdata !== e.data) begin
                errors++;
                $display("FAIL %s: rdata actual %0h expected %0h", e.req, bus_rdata, e.data);
            end
        end
    end

    task automatic bus_read(input logic [1:0] a, input logic [NUM_CH-1:0] tc, input string req);
        exp_t e;
        logic [NUM_CH-1:0] w;
        e.data = m_read(a);
        e.req  = req;
        exp_q.push_back(e);
        w = m_winner();
        bus_addr = a; bus_rd = 1'b1; tc_pulse = tc;
        @(negedge clk);
        bus_rd = 1'b0; tc_pulse = '0;
        if (a == 2'd2) m_flags = m_flags & ~w;
        m_flags = m_flags | tc;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
        logic [NUM_CH-1:0] w;
        w = m_winner();
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            2'd0: m_flags = m_flags & ~d[NUM_CH-1:0];
            2'd1: m_en = d[NUM_CH-1:0];
            2'd2: m_flags = m_flags & ~w;
            default: m_gie = d[0];
        endcase
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] tc);
        tc_pulse = tc;
        @(negedge clk);
        tc_pulse = '0;
        m_flags = m_flags | tc;
    endtask

    task automatic check_irq(input string req);
        logic exp;
        exp = m_gie && |(m_flags & m_en);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check_irq("R11 irq after reset");
        bus_read(2'd0, '0, "R11 flags after reset");
        bus_read(2'd1, '0, "R11 enables after reset");
        bus_read(2'd3, '0, "R11 ctrl after reset");
        bus_read(2'd2, '0, "R11 vector after reset");

        // R1, R2, R6: flag set while disabled
        pulse(3'b010);
        bus_read(2'd0, '0, "R1 flag set by pulse");
        check_irq("R2 no irq while disabled");
        bus_read(2'd2, '0, "R6 disabled flag gives code 0");
        bus_read(2'd0, '0, "R6 disabled flag kept after vector read");

        // R10, R2: enables and global enable
        bus_write(2'd1, 16'h0007);
        bus_read(2'd1, '0, "R10 enable readback");
        check_irq("R2 no irq while global enable off");
        bus_write(2'd3, 16'h0001);
        bus_read(2'd3, '0, "R10 ctrl readback");
        check_irq("R2 irq with flag enable and global");

        // R4, R5, R7, R8: service several channels in priority order
        pulse(3'b101);
        bus_read(2'd2, '0, "R4 R5 channel 0 code");
        check_irq("R8 irq stays with pending flags");
        bus_read(2'd0, '0, "R7 only channel 0 cleared");
        bus_read(2'd2, '0, "R4 channel 1 code next");
        bus_write(2'd2, 16'h0000);
        bus_read(2'd0, '0, "R7 vector write cleared channel 2");
        check_irq("R2 irq low when none pending");

        // R6, R7: masked higher channel is skipped
        bus_write(2'd1, 16'h0006);
        pulse(3'b101);
        bus_read(2'd2, '0, "R6 masked channel 0 skipped");
        bus_read(2'd0, '0, "R7 channel 2 cleared, channel 0 kept");
        check_irq("R2 no irq from masked flag");

        // R3: no self clear, selective W1C
        repeat (5) @(negedge clk);
        bus_read(2'd0, '0, "R3 flag holds while idle");
        pulse(3'b110);
        bus_write(2'd0, 16'h0003);
        bus_read(2'd0, '0, "R3 write clears only selected flags");

        // R9: pulse coincides with vector access clearing the same flag
        bus_write(2'd0, 16'h0007);
        bus_write(2'd1, 16'h0007);
        pulse(3'b010);
        bus_read(2'd2, 3'b010, "R9 code with coincident pulse");
        bus_read(2'd0, '0, "R9 flag survives coincident clear");
        check_irq("R9 irq still raised");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: pending reads actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule